// File: doc/BRIEF.md
# Sync-Referenced Processing Window Gate

This block sits beside a video input port. It watches the horizontal sync, vertical sync and pixel-valid signals and raises a one-cycle qualifier for each pixel that lies inside a programmed processing rectangle. The rectangle is given by four values. A first pixel and a pixel count apply along each line, and a pixel index restarts at every horizontal sync active edge. A first line and a line count apply down each field, and a line index restarts at every vertical sync active edge.

The block also works out the parity of each field. A vertical sync edge that arrives while horizontal sync is asserted marks an even field. An edge that arrives in the visible part of a line marks an odd field. Host software sets a run bit to start capture. Capture then waits for the next field whose parity matches a programmed first-field choice, pulses a start strobe, and processes every field after that until the run bit drops.

Typical use is to feed the qualifier to a downstream pixel datapath as its write enable, and to use the start strobe to reset that datapath's frame bookkeeping.

Top module: `video_window_gate`

## Requirements
- R1: The pixel index is the number of `pix_vld` cycles since the most recent horizontal sync active edge. A valid pixel in the edge cycle itself has index 0. A window pixel needs an index in [`pix_first`, `pix_first`+`pix_count`), so a count of zero gives no window pixels.
- R2: The line index is 0 from the cycle of a vertical sync active edge. It rises by one at each later horizontal sync active edge that does not coincide with a vertical edge. A window pixel needs a line index in [`line_first`, `line_first`+`line_count`).
- R3: At each vertical sync active edge, `field_odd_o` is loaded the following cycle. It is 0 (even) if `hsync_in` was active in the edge cycle and 1 (odd) otherwise. It holds until the next vertical edge.
- R4: While `host_run` is 0, neither `win_vld_o` nor `start_o` is asserted in the following cycle.
- R5: After `host_run` rises, no window pixel is produced until a vertical sync edge whose parity equals `first_odd` (1 selects odd, 0 selects even). `start_o` pulses for exactly one cycle, the cycle after that edge.
- R6: Once started, every later field is processed whatever its parity. Dropping `host_run` stops window output from the next cycle, and a new start again waits for the selected parity.
- R7: `win_vld_o` is registered. It is high one cycle after an input cycle that qualifies and never follows a cycle without `pix_vld`.
- R8: After reset, `win_vld_o` and `start_o` are 0 and `field_odd_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync (active level set by parameter) |
| vsync_in | input | 1 | Vertical sync (active level set by parameter) |
| pix_vld | input | 1 | Pixel present this cycle |
| host_run | input | 1 | Host run command |
| first_odd | input | 1 | Parity of the first field to process, 1 = odd |
| pix_first | input | PIX_W | First processed pixel in a line (suggested 0) |
| pix_count | input | PIX_W | Processed pixels per line (suggested 640) |
| line_first | input | LINE_W | First processed line in a field (suggested 10) |
| line_count | input | LINE_W | Processed lines per field (suggested 240) |
| win_vld_o | output | 1 | Pixel inside the processing window |
| field_odd_o | output | 1 | Parity of the current field, 1 = odd |
| start_o | output | 1 | One-cycle pulse when processing begins |

## Verification
The gate is driven with whole fields of a short synthetic line timing. Even fields raise vertical sync together with horizontal sync. Odd fields raise it mid-line. Counting the window pixels per field and recording the first and last of them shows whether both indexes start at the right edge and whether both ranges are half-open. Fields of the wrong parity placed before and after arming show the parity gate is applied only once. A field with gaps in pixel-valid shows that only valid cycles advance the pixel index. A field where the run bit drops partway through shows that output stops at once.

// File: rtl/vwg_pkg.sv
`timescale 1ns/1ps
package vwg_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_RUN   = 2'd2
   } run_state_t;
endpackage

// File: rtl/vwg_sync_edge.sv
`timescale 1ns/1ps
module vwg_sync_edge #(
   parameter bit ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   output logic act_o,
   output logic rise_o
);
   logic prev_q;

   generate
      if (ACTIVE_HIGH) begin : g_hi
         assign act_o = sync_in;
      end else begin : g_lo
         assign act_o = ~sync_in;
      end
   endgenerate

   // Start as "already active" so no edge is seen out of reset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= act_o;
   end

   assign rise_o = act_o & ~prev_q;

   // R3: an active edge can never repeat on the next cycle
   assert_single_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/vwg_axis_track.sv
`timescale 1ns/1ps
module vwg_axis_track #(
   parameter int W        = 12,
   parameter bit POST_INC = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         adv,
   input  logic [W-1:0] first,
   input  logic [W-1:0] count,
   output logic         in_win_o
);
   localparam logic [W-1:0] MAXV = '1;

   logic [W-1:0] cnt_q, idx, nxt;
   logic [W:0]   lo, hi, ix;

   function automatic logic [W-1:0] bump(input logic [W-1:0] v);
      return (v == MAXV) ? v : v + W'(1);
   endfunction

   generate
      if (POST_INC) begin : g_post
         // index already includes this cycle's advance (line counting)
         always_comb begin
            idx = clr ? '0 : (adv ? bump(cnt_q) : cnt_q);
            nxt = idx;
         end
      end else begin : g_pre
         // index names the item of this cycle, advance applies after it
         always_comb begin
            idx = clr ? '0 : cnt_q;
            nxt = adv ? bump(idx) : idx;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= nxt;
   end

   always_comb begin
      lo       = {1'b0, first};
      hi       = lo + {1'b0, count};
      ix       = {1'b0, idx};
      in_win_o = (ix >= lo) && (ix < hi);
   end

   // R1 and R2: between restarts the index never goes backwards
   assert_count_monotone_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/vwg_field_ctl.sv
`timescale 1ns/1ps
module vwg_field_ctl
   import vwg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic vs_rise,
   input  logic hs_act,
   input  logic host_run,
   input  logic first_odd,
   output logic run_nx_o,
   output logic field_odd_o,
   output logic start_o
);
   run_state_t st_q, st_nx;
   logic       par_odd;

   assign par_odd = ~hs_act;

   always_comb begin
      st_nx = st_q;
      unique case (st_q)
         ST_IDLE:  if (host_run) st_nx = ST_ARMED;
         ST_ARMED: begin
            if (!host_run)                            st_nx = ST_IDLE;
            else if (vs_rise && (par_odd == first_odd)) st_nx = ST_RUN;
         end
         ST_RUN:   if (!host_run) st_nx = ST_IDLE;
         default:  st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         field_odd_o <= 1'b1;
         start_o     <= 1'b0;
      end else begin
         st_q    <= st_nx;
         start_o <= (st_q == ST_ARMED) && (st_nx == ST_RUN);
         if (vs_rise) field_odd_o <= par_odd;
      end
   end

   assign run_nx_o = (st_nx == ST_RUN);

   // R5: the start strobe lasts one cycle
   assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o);
   // R5: the started field has the selected parity
   assert_start_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> (field_odd_o == $past(first_odd)));
   // R4: no start without the run command
   assert_start_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> $past(host_run));
endmodule

// File: rtl/video_window_gate.sv
`timescale 1ns/1ps
module video_window_gate #(
   parameter int PIX_W            = 12,
   parameter int LINE_W           = 11,
   parameter bit SYNC_ACTIVE_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hsync_in,
   input  logic              vsync_in,
   input  logic              pix_vld,
   input  logic              host_run,
   input  logic              first_odd,
   input  logic [PIX_W-1:0]  pix_first,
   input  logic [PIX_W-1:0]  pix_count,
   input  logic [LINE_W-1:0] line_first,
   input  logic [LINE_W-1:0] line_count,
   output logic              win_vld_o,
   output logic              field_odd_o,
   output logic              start_o
);
   generate
      if (PIX_W < 2 || PIX_W > 16) begin : g_bad_pix
         $error("video_window_gate: PIX_W out of range");
      end
      if (LINE_W < 2 || LINE_W > 16) begin : g_bad_line
         $error("video_window_gate: LINE_W out of range");
      end
   endgenerate

   logic hs_act, hs_rise, vs_act, vs_rise;
   logic px_in, ln_in, run_nx;

   vwg_sync_edge #(.ACTIVE_HIGH(SYNC_ACTIVE_HIGH)) u_hs (
      .clk(clk), .rst_n(rst_n), .sync_in(hsync_in),
      .act_o(hs_act), .rise_o(hs_rise));

   vwg_sync_edge #(.ACTIVE_HIGH(SYNC_ACTIVE_HIGH)) u_vs (
      .clk(clk), .rst_n(rst_n), .sync_in(vsync_in),
      .act_o(vs_act), .rise_o(vs_rise));

   vwg_axis_track #(.W(PIX_W), .POST_INC(1'b0)) u_px (
      .clk(clk), .rst_n(rst_n), .clr(hs_rise), .adv(pix_vld),
      .first(pix_first), .count(pix_count), .in_win_o(px_in));

   vwg_axis_track #(.W(LINE_W), .POST_INC(1'b1)) u_ln (
      .clk(clk), .rst_n(rst_n), .clr(vs_rise), .adv(hs_rise),
      .first(line_first), .count(line_count), .in_win_o(ln_in));

   vwg_field_ctl u_fc (
      .clk(clk), .rst_n(rst_n), .vs_rise(vs_rise), .hs_act(hs_act),
      .host_run(host_run), .first_odd(first_odd), .run_nx_o(run_nx),
      .field_odd_o(field_odd_o), .start_o(start_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_vld_o <= 1'b0;
      else        win_vld_o <= run_nx & pix_vld & px_in & ln_in;
   end

   // R7: a window pixel always follows a valid input pixel
   assert_win_needs_pixel_R7: assert property (@(posedge clk) disable iff (!rst_n)
      win_vld_o |-> $past(pix_vld));
   // R4: a window pixel always follows a cycle with the run command high
   assert_win_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
      win_vld_o |-> $past(host_run));
   // R5: a start follows a cycle with vertical sync active
   assert_start_on_vsync_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> $past(vs_act));
endmodule

// File: tb/sim_video_window_gate.sv
`timescale 1ns/1ps
module sim_video_window_gate;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hsync_in = 1'b0, vsync_in = 1'b0, pix_vld = 1'b0;
   logic host_run = 1'b0, first_odd = 1'b1;
   logic [11:0] pix_first = 12'd2, pix_count = 12'd3;
   logic [10:0] line_first = 11'd1, line_count = 11'd2;
   logic win_vld_o, field_odd_o, start_o;

   int checks = 0, fails = 0;
   int wins, sops, bad_pv, first_l, first_p, last_l, last_p;
   int cur_l, cur_p;
   bit cur_pv;

   always #2.5 clk = ~clk;

   video_window_gate u0 (
      .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
      .pix_vld(pix_vld), .host_run(host_run), .first_odd(first_odd),
      .pix_first(pix_first), .pix_count(pix_count),
      .line_first(line_first), .line_count(line_count),
      .win_vld_o(win_vld_o), .field_odd_o(field_odd_o), .start_o(start_o));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_stats();
      wins = 0; sops = 0; bad_pv = 0;
      first_l = -1; first_p = -1; last_l = -1; last_p = -1;
   endtask

   task automatic cyc(input bit hs, input bit vs, input bit pv);
      hsync_in = hs; vsync_in = vs; pix_vld = pv; cur_pv = pv;
      @(posedge clk); #1;
      if (win_vld_o) begin
         if (wins == 0) begin first_l = cur_l; first_p = cur_p; end
         last_l = cur_l; last_p = cur_p;
         wins++;
         if (!cur_pv) bad_pv++;
      end
      if (start_o) sops++;
      if (pv) cur_p++;
   endtask

   task automatic idle(input int n);
      cur_l = -1;
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0);
   endtask

   // four lines of ten cycles: two sync cycles then eight pixel cycles
   task automatic field(input bit odd, input bit gap, input int stop_l);
      clear_stats();
      for (int l = 0; l < 4; l++) begin
         cur_l = l; cur_p = 0;
         if (l == stop_l) host_run = 1'b0;
         for (int c = 0; c < 10; c++)
            cyc(c < 2, (l == 0) && (odd ? (c >= 6) : 1'b1),
                (c >= 2) && (!gap || (c % 2 == 0)));
      end
   endtask

   task automatic t_reset();
      chk("R8 win after reset", win_vld_o, 0);
      chk("R8 start after reset", start_o, 0);
      chk("R8 field after reset", field_odd_o, 1);
   endtask

   task automatic t_idle();
      host_run = 1'b0; idle(3);
      field(1'b0, 1'b0, -1);
      chk("R4 no window while stopped", wins, 0);
      chk("R4 no start while stopped", sops, 0);
      chk("R3 even field type", field_odd_o, 0);
      field(1'b1, 1'b0, -1);
      chk("R4 no window while stopped odd", wins, 0);
      chk("R3 odd field type", field_odd_o, 1);
   endtask

   task automatic t_arm_odd();
      first_odd = 1'b1; host_run = 1'b1; idle(3);
      field(1'b0, 1'b0, -1);
      chk("R5 wrong parity no window", wins, 0);
      chk("R5 wrong parity no start", sops, 0);
      field(1'b1, 1'b0, -1);
      chk("R5 start once on odd", sops, 1);
      chk("R1 R2 window count", wins, 6);
      chk("R2 first window line", first_l, 1);
      chk("R1 first window pixel", first_p, 2);
      chk("R2 last window line", last_l, 2);
      chk("R1 last window pixel", last_p, 4);
      field(1'b0, 1'b0, -1);
      chk("R6 even field after start", wins, 6);
      chk("R6 no second start", sops, 0);
   endtask

   task automatic t_gap();
      field(1'b1, 1'b1, -1);
      chk("R7 gapped window count", wins, 4);
      chk("R7 window only on valid", bad_pv, 0);
      chk("R1 gapped first pixel", first_p, 2);
   endtask

   task automatic t_bounds();
      pix_first = 12'd7; pix_count = 12'd1;
      line_first = 11'd3; line_count = 11'd1;
      idle(2);
      field(1'b0, 1'b0, -1);
      chk("R1 R2 edge window count", wins, 1);
      chk("R2 edge line", first_l, 3);
      chk("R1 edge pixel", first_p, 7);
      pix_count = 12'd0;
      field(1'b1, 1'b0, -1);
      chk("R1 zero count no window", wins, 0);
      pix_first = 12'd2; pix_count = 12'd3;
      line_first = 11'd1; line_count = 11'd2;
      idle(2);
   endtask

   task automatic t_stop_rearm();
      field(1'b1, 1'b0, 2);
      chk("R6 stop mid field count", wins, 3);
      chk("R6 stop mid field last line", last_l, 1);
      field(1'b0, 1'b0, -1);
      chk("R4 stopped after drop", wins, 0);
      first_odd = 1'b0; host_run = 1'b1; idle(3);
      field(1'b1, 1'b0, -1);
      chk("R5 rearm odd skipped", wins, 0);
      chk("R5 rearm odd no start", sops, 0);
      field(1'b0, 1'b0, -1);
      chk("R5 rearm even start", sops, 1);
      chk("R5 rearm even window count", wins, 6);
   endtask

   initial begin
      #500000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      clear_stats();
      cur_l = -1; cur_p = 0; cur_pv = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      idle(4);
      t_idle();
      t_arm_odd();
      t_gap();
      t_bounds();
      t_stop_rearm();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule